// File: doc/BRIEF.md
# Multidrop-capable serial transceiver

This block is an asynchronous serial transmitter and receiver sharing one baud generator. The word length is set from 4 to 8 bits, and an optional parity bit, even or odd, can be added. Each bit lasts 16 ticks of the baud generator. A tick comes every `baud_div + 1` clock cycles, so one bit lasts `16 * (baud_div + 1)` cycles. The receiver oversamples the line and takes each bit by a vote of three samples around the bit centre.

In multidrop mode every frame carries eight payload bits and a ninth flag bit that marks the payload as a node address. The receiver forwards only the traffic meant for its node. An address frame that equals `node_addr` is delivered and opens acceptance of the data frames that follow. Any other address frame is dropped and closes acceptance. Data frames that arrive while acceptance is closed are dropped.

Both data paths use valid/ready streams. The transmitter raises `tx_ready` only when idle and takes a frame on a cycle where `tx_valid` and `tx_ready` are both high. The receiver has a single holding register. While `rx_valid` is high and `rx_ready` is low, the output word is held stable. A frame that completes during that time is discarded. Configuration inputs are sampled when each frame starts.

Top module: `uart_mdrop`

## Requirements
- R1: A transmitted frame is one low start bit, then the data bits LSB first, then the parity or flag bit when present, then one high stop bit. Each bit is 16*(baud_div+1) cycles. The line idles high.
- R2: Data length comes from cfg_len. Values 4 to 8 give that many bits. A value below 4 acts as 4 and a value above 8 acts as 8. Received data is zero-extended in rx_data.
- R3: With par_en=1 outside multidrop mode, the bit after the data is the XOR of the data bits when par_odd=0 (even), and its inverse when par_odd=1 (odd).
- R4: Outside multidrop mode the receiver delivers every well-formed frame on rx_data with rx_is_addr=0.
- R5: A received parity mismatch pulses err_parity for one cycle, and the frame is still delivered.
- R6: A low stop bit pulses err_frame for one cycle and the frame is still delivered. The next frame is received normally.
- R7: Each received bit is the majority of three samples around its centre, so a disturbance hitting a single sample is ignored. A low pulse shorter than half a bit is not taken as a start bit.
- R8: With addr_en=1 a frame has 8 data bits and a flag bit (1 = address, 0 = data). Parity is neither sent nor checked. The transmitter sends tx_addr as the flag.
- R9: In multidrop mode an address frame equal to node_addr is delivered with rx_is_addr=1 and opens acceptance. Any other address frame is dropped and closes acceptance. Data frames are delivered only while acceptance is open. Acceptance is closed after reset and whenever addr_en=0.
- R10: While rx_valid=1 and rx_ready=0, rx_valid, rx_data and rx_is_addr stay stable. A frame completing in that time is discarded.
- R11: tx_ready is high only while the transmitter is idle, and txd is high whenever tx_ready is high. A frame is taken when tx_valid and tx_ready are both high at a clock edge.
- R12: After reset, txd=1, tx_ready=1, rx_valid=0, err_frame=0 and err_parity=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Tick period minus one; a bit lasts 16 ticks |
| cfg_len | input | 4 | Data bits per frame (4..8, clamped) |
| par_en | input | 1 | Add and check a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| addr_en | input | 1 | Multidrop mode with a ninth address-flag bit |
| node_addr | input | 8 | Address of this node |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle and able to take a word |
| tx_data | input | 8 | Transmit word |
| tx_addr | input | 1 | Flag bit sent in multidrop mode |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 8 | Received word, zero-extended |
| rx_is_addr | output | 1 | Received word is a node address |
| err_frame | output | 1 | One-cycle pulse: stop bit read low |
| err_parity | output | 1 | One-cycle pulse: parity mismatch |

## Verification
The bench sweeps every length from 4 to 8 under no, even and odd parity in both directions. A design that places the parity bit at a fixed position, or computes it over masked-off bits, produces wrong frames at the short lengths. The filter sequence mixes foreign addresses, the node's own address and data before, between and after them. A design that never closes acceptance, or that forwards foreign addresses, delivers extra words. A glitch inside a bit and a short low pulse on an idle line catch a receiver that trusts a single sample. Two frames sent under held back-pressure catch a holding register that is overwritten.

// File: rtl/uart_mdrop_pkg.sv
package uart_mdrop_pkg;
  localparam int DATA_W  = 8;
  localparam int MIN_LEN = 4;
  localparam int OVS     = 16;
  localparam int OVS_W   = $clog2(OVS);
  localparam int LEN_W   = $clog2(DATA_W + 1);
  localparam int SH_W    = DATA_W + 1;
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (l < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
    if (l > LEN_W'(DATA_W))  return LEN_W'(DATA_W);
    return l;
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(l));
    return m;
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_mdrop_baud.sv
module uart_mdrop_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= div;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_mdrop_tx.sv
module uart_mdrop_tx
  import uart_mdrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              addr_en,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  output logic              tx_ready,
  output logic              txd
);
  logic [LEN_W-1:0]   len_e;
  logic [DATA_W-1:0]  masked;
  logic               ext_en, ext_bit;
  logic [FRAME_W-1:0] frame_c, sreg;
  logic [CNT_W-1:0]   nbits_c, left;
  logic [OVS_W-1:0]   ovs;
  logic               busy;

  always_comb begin
    len_e   = addr_en ? LEN_W'(DATA_W) : clamp_len(cfg_len);
    masked  = tx_data & len_mask(len_e);
    ext_en  = addr_en | par_en;
    ext_bit = addr_en ? tx_addr : ((^masked) ^ par_odd);
    frame_c = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(len_e)) frame_c[i+1] = tx_data[i];
    if (ext_en) frame_c[int'(len_e)+1] = ext_bit;
    nbits_c = CNT_W'(len_e) + CNT_W'(2) + CNT_W'(ext_en);
  end

  assign tx_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sreg <= '1;
      left <= '0;
      ovs  <= '0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (tx_valid) begin
        busy <= 1'b1;
        sreg <= frame_c;
        txd  <= frame_c[0];
        left <= nbits_c - 1'b1;
        ovs  <= '0;
      end
    end else if (tick) begin
      ovs <= ovs + 1'b1;
      if (ovs == OVS_W'(OVS - 1)) begin
        if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          sreg <= {1'b1, sreg[FRAME_W-1:1]};
          txd  <= sreg[1];
          left <= left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_mdrop_rx.sv
module uart_mdrop_rx
  import uart_mdrop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              addr_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              rxd,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_addr,
  output logic              err_frame,
  output logic              err_parity
);
  logic              sy1, rx_s, s7, s8, vote;
  rx_state_e         state;
  logic [OVS_W-1:0]  ovs;
  logic [LEN_W-1:0]  bitcnt, l_len, nbits;
  logic              l_par, l_odd, l_am, accept;
  logic [SH_W-1:0]   shreg, aligned;
  logic [DATA_W-1:0] word;
  logic              ext, done, is_addr, hit, par_bad, keep;

  // two-stage synchronizer for the asynchronous line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1  <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      sy1  <= rxd;
      rx_s <= sy1;
    end
  end

  always_comb begin
    vote    = maj3(s7, s8, rx_s);
    nbits   = l_len + LEN_W'(l_par | l_am);
    aligned = shreg >> (LEN_W'(SH_W) - nbits);
    word    = aligned[DATA_W-1:0] & len_mask(l_len);
    ext     = aligned[l_len];
    done    = tick && (state == RX_STOP) && (ovs == OVS_W'(9));
    is_addr = l_am && ext;
    hit     = (word == node_addr);
    par_bad = l_par && !l_am && (ext != ((^word) ^ l_odd));
    keep    = !l_am || (is_addr ? hit : (!ext && accept));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      ovs    <= '0;
      s7     <= 1'b1;
      s8     <= 1'b1;
      bitcnt <= '0;
      shreg  <= '0;
      l_len  <= LEN_W'(DATA_W);
      l_par  <= 1'b0;
      l_odd  <= 1'b0;
      l_am   <= 1'b0;
    end else if (tick) begin
      if (state == RX_IDLE) begin
        if (!rx_s) begin
          state <= RX_START;
          ovs   <= OVS_W'(1);
          l_len <= addr_en ? LEN_W'(DATA_W) : clamp_len(cfg_len);
          l_par <= par_en;
          l_odd <= par_odd;
          l_am  <= addr_en;
        end
      end else begin
        ovs <= ovs + 1'b1;
        if (ovs == OVS_W'(7)) s7 <= rx_s;
        if (ovs == OVS_W'(8)) s8 <= rx_s;
        if (ovs == OVS_W'(9)) begin
          case (state)
            RX_START: if (vote) state <= RX_IDLE;
            RX_DATA:  shreg <= {vote, shreg[SH_W-1:1]};
            RX_STOP:  state <= RX_IDLE;
            default:  ;
          endcase
        end
        if (ovs == OVS_W'(OVS - 1)) begin
          if (state == RX_START) begin
            state  <= RX_DATA;
            bitcnt <= '0;
          end else if (state == RX_DATA) begin
            if (bitcnt == nbits - 1'b1) state <= RX_STOP;
            else bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_is_addr <= 1'b0;
      err_frame  <= 1'b0;
      err_parity <= 1'b0;
    end else begin
      err_frame  <= done && !vote;
      err_parity <= done && par_bad;
      if (!addr_en) accept <= 1'b0;
      else if (done && is_addr) accept <= hit;
      if (done && keep && (!rx_valid || rx_ready)) begin
        rx_valid   <= 1'b1;
        rx_data    <= word;
        rx_is_addr <= is_addr;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_mdrop.sv
module uart_mdrop
  import uart_mdrop_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              addr_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_addr,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_is_addr,
  output logic              err_frame,
  output logic              err_parity
);
  logic tick;

  uart_mdrop_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  uart_mdrop_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .par_en(par_en), .par_odd(par_odd), .addr_en(addr_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_addr(tx_addr),
    .tx_ready(tx_ready), .txd(txd)
  );

  uart_mdrop_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .par_en(par_en), .par_odd(par_odd), .addr_en(addr_en),
    .node_addr(node_addr), .rxd(rxd), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_is_addr(rx_is_addr),
    .err_frame(err_frame), .err_parity(err_parity)
  );
endmodule

// File: rtl/uart_mdrop_chk.sv
module uart_mdrop_chk
  import uart_mdrop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] node_addr,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              txd,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_is_addr,
  input logic              err_frame,
  input logic              err_parity
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_is_addr));

  p_idle_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> !txd);

  p_par_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> !err_parity);

  p_frm_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame |=> !err_frame);

  p_own_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && rx_is_addr |-> rx_data == $past(node_addr));
endmodule

bind uart_mdrop uart_mdrop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txd(txd), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_is_addr(rx_is_addr), .err_frame(err_frame),
  .err_parity(err_parity)
);

// File: tb/uart_mdrop_test.sv
module uart_mdrop_test;
  localparam int BIT = 32; // baud_div = 1 -> 16 * 2 cycles

  logic       clk = 0, rst_n = 0;
  logic [15:0] baud_div = 16'd1;
  logic [3:0] cfg_len = 4'd8;
  logic       par_en = 0, par_odd = 0, addr_en = 0;
  logic [7:0] node_addr = 8'h5A;
  logic       tx_valid = 0, tx_ready, tx_addr = 0, txd;
  logic [7:0] tx_data = 0, rx_data;
  logic       rxd = 1, rx_valid, rx_ready = 1, rx_is_addr, err_frame, err_parity;

  int n_chk = 0, n_err = 0;
  int log_n = 0, fe_n = 0, pe_n = 0;
  logic [8:0] log_q [0:63];
  bit finished = 0;

  uart_mdrop uut (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_ready) begin
        if (log_n < 64) log_q[log_n] = {rx_is_addr, rx_data};
        log_n++;
      end
      if (err_frame)  fe_n++;
      if (err_parity) pe_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampl(input int l);
    return (l < 4) ? 4 : ((l > 8) ? 8 : l);
  endfunction

  function automatic void mk(input logic [7:0] d, input int len, input bit pen, input bit podd,
                             input bit am, input bit af, output logic [11:0] f, output int n);
    int L, ones;
    L = am ? 8 : clampl(len);
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < L; i++) begin
      f[1+i] = d[i];
      ones += int'(d[i]);
    end
    n = L + 2;
    if (am) begin
      f[L+1] = af; n++;
    end else if (pen) begin
      f[L+1] = podd ^ ones[0]; n++;
    end
  endfunction

  task automatic send_rx(input logic [11:0] f, input int n, input int g);
    for (int i = 0; i < n; i++)
      for (int c = 0; c < BIT; c++) begin
        rxd = (i == g && (c == 15 || c == 16)) ? ~f[i] : f[i];
        @(negedge clk);
      end
    rxd = 1'b1;
    repeat (2*BIT) @(negedge clk);
  endtask

  task automatic tx_frame(input logic [7:0] d, input bit af, input string req);
    logic [11:0] f, got;
    int n;
    mk(d, int'(cfg_len), par_en, par_odd, addr_en, af, f, n);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_addr = af; tx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    while (txd) @(negedge clk);
    repeat (15) @(negedge clk);
    got = '1;
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) chk(!tx_ready, {req, " R11 busy"}, 32'(tx_ready), 0);
      repeat (BIT) @(negedge clk);
    end
    chk(got == f, req, 32'(got), 32'(f));
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit af, input bit keep,
                          input logic [7:0] exp_d, input bit exp_a, input string req);
    logic [11:0] f;
    int n, b;
    mk(d, int'(cfg_len), par_en, par_odd, addr_en, af, f, n);
    b = log_n;
    send_rx(f, n, -1);
    chk(log_n == b + (keep ? 1 : 0), {req, " count"}, 32'(log_n - b), keep ? 1 : 0);
    if (keep && log_n > b)
      chk(log_q[b] == {exp_a, exp_d}, req, 32'(log_q[b]), 32'({exp_a, exp_d}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] f;
    int n, b, fe0, pe0;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(txd == 1 && tx_ready == 1, "R12 tx idle", {txd, tx_ready}, 2'b11);
    chk(rx_valid == 0 && err_frame == 0 && err_parity == 0, "R12 rx idle",
        {rx_valid, err_frame, err_parity}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4: sweep lengths and parity modes in both directions
    for (int len = 4; len <= 8; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int j = 0; j < 3; j++) begin
          cfg_len = 4'(len); par_en = (pm != 0); par_odd = (pm == 2);
          d = 8'((len * 53 + pm * 29 + j * 91) & 255);
          tx_frame(d, 0, "R1 R2 R3 tx frame");
          fe0 = fe_n; pe0 = pe_n;
          rx_frame(d, 0, 1, d & 8'((1 << len) - 1), 0, "R2 R3 R4 rx word");
          chk(fe_n == fe0 && pe_n == pe0, "R4 no error", 32'(fe_n + pe_n), 32'(fe0 + pe0));
        end

    // R2 clamping of out-of-range lengths
    par_en = 0; cfg_len = 4'd2;
    tx_frame(8'hB6, 0, "R2 clamp low");
    cfg_len = 4'd12;
    tx_frame(8'hB6, 0, "R2 clamp high");

    // R5 parity error, still delivered
    cfg_len = 8; par_en = 1; par_odd = 0;
    mk(8'h5C, 8, 1, 0, 0, 0, f, n);
    f[9] = ~f[9];
    b = log_n; pe0 = pe_n; fe0 = fe_n;
    send_rx(f, n, -1);
    chk(pe_n == pe0 + 1, "R5 parity flag", 32'(pe_n - pe0), 1);
    chk(log_n == b + 1 && log_q[b] == 9'h05C, "R5 data kept", 32'(log_q[b]), 9'h05C);

    // R6 framing error, next frame fine
    mk(8'h93, 8, 1, 0, 0, 0, f, n);
    f[n-1] = 1'b0;
    b = log_n; fe0 = fe_n; pe0 = pe_n;
    send_rx(f, n, -1);
    repeat (2*BIT) @(negedge clk);
    chk(fe_n == fe0 + 1, "R6 frame flag", 32'(fe_n - fe0), 1);
    chk(log_n == b + 1 && log_q[b] == 9'h093, "R6 data kept", 32'(log_q[b]), 9'h093);
    rx_frame(8'h3E, 0, 1, 8'h3E, 0, "R6 next frame");
    chk(fe_n == fe0 + 1 && pe_n == pe0, "R6 no new error", 32'(fe_n + pe_n), 32'(fe0 + 1 + pe0));

    // R7 glitch inside a bit and a short false start
    par_en = 0;
    mk(8'h00, 8, 0, 0, 0, 0, f, n);
    b = log_n;
    send_rx(f, n, 4);
    chk(log_n == b + 1 && log_q[b] == 9'h000, "R7 glitch voted out", 32'(log_q[b]), 0);
    b = log_n;
    rxd = 0; repeat (6) @(negedge clk);
    rxd = 1; repeat (14*BIT) @(negedge clk);
    chk(log_n == b, "R7 short start ignored", 32'(log_n - b), 0);

    // R8 multidrop transmit: flag sent, parity unused
    addr_en = 1; par_en = 1; cfg_len = 4;
    tx_frame(8'h5A, 1, "R8 tx address frame");
    tx_frame(8'hC3, 0, "R8 tx data frame");

    // R9 address filtering sequence
    rx_frame(8'h11, 0, 0, 0, 0, "R9 data before match");
    rx_frame(8'h33, 1, 0, 0, 0, "R9 foreign address");
    rx_frame(8'h22, 0, 0, 0, 0, "R9 data after foreign");
    rx_frame(8'h5A, 1, 1, 8'h5A, 1, "R9 own address");
    rx_frame(8'h44, 0, 1, 8'h44, 0, "R8 R9 data accepted");
    rx_frame(8'h55, 0, 1, 8'h55, 0, "R9 data accepted again");
    rx_frame(8'h77, 1, 0, 0, 0, "R9 foreign closes");
    rx_frame(8'h66, 0, 0, 0, 0, "R9 data after close");
    addr_en = 0; par_en = 0; cfg_len = 8;
    rx_frame(8'h12, 0, 1, 8'h12, 0, "R4 R9 mode off");

    // R10 back-pressure
    @(posedge clk); #1 rx_ready = 0;
    b = log_n;
    mk(8'h21, 8, 0, 0, 0, 0, f, n);
    send_rx(f, n, -1);
    mk(8'h43, 8, 0, 0, 0, 0, f, n);
    send_rx(f, n, -1);
    chk(rx_valid == 1 && rx_data == 8'h21, "R10 held word", 32'({rx_valid, rx_data}), 9'h121);
    @(posedge clk); #1 rx_ready = 1;
    repeat (4) @(negedge clk);
    chk(log_n == b + 1 && log_q[b] == 9'h021, "R10 single delivery", 32'(log_n - b), 1);
    chk(rx_valid == 0, "R10 drained", 32'(rx_valid), 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule